// File: doc/BRIEF.md
# Exception Entry and Fault Capture

This block performs exception entry for a 64-bit core. Each cycle it looks at a vector of fault-class requests, picks one by fixed priority, and on the next clock redirects fetch into the privileged handler region. The new PC is a software-loaded handler base plus a vector offset fixed per class, and the next PC is that value plus 4. While entering the handler it also records the exception restart address, and captures the memory-management fault state the handler needs.

For data translation faults it captures three things: the faulting virtual address, a status word packed from instruction fields and access flags, and a formatted page-table address. For instruction translation faults it captures the faulting PC and its formatted page-table address. Speculative requests skip this capture, and so do page-table-entry loads and no-fault accesses. The block keeps a saturating entry counter per class. A request for the arithmetic trap path is not serviced: it raises a sticky error flag.

The handler base and the two page-table bases are written through a small configuration port. `cfg_sel` selects the register: 0 is the handler base, 1 is the data page-table base, 2 is the instruction page-table base.

Top module: `exc_entry`

## Requirements
- R1: While `rst_n` is low, every output register is held at zero: `redirect`, the PCs, the capture registers, the counters and `unsup_err`.
- R2: Suppose any bit of `fault_req` is set at a clock edge. Then `redirect` is 1 for the following cycle, `new_pc` equals handler base plus the class offset, and `next_pc` equals `new_pc` + 4. With no request, `redirect` is 0.
- R3: Class offsets by `fault_req` bit are as follows.
  - Bit 0 (reset): 0x0001.
  - Bit 1 (machine check): 0x0401.
  - Bit 2 (instruction translation miss): 0x0181.
  - Bit 3 (instruction access violation): 0x0081.
  - Bit 4 (illegal opcode): 0x0481.
  - Bit 5 (float disabled): 0x0581.
  - Bit 6 (privileged call): 0x2001.
  - Bit 7 (data single miss): 0x0201.
  - Bit 8 (data double miss): 0x0281.
  - Bit 9 (data page or access fault): 0x0381.
  - Bit 10 (data alignment): 0x0301.
  - Bit 11 (interrupt): 0x0101.
- R4: When several bits are set, the lowest-numbered bit wins.
- R5: For every class except bit 6, `exc_addr` is loaded with the current `pc`.
- R6: For bit 6, `exc_addr` becomes `pc` + 4 when `pc[1:0]` is 0. Otherwise it becomes its previous value + 4.
- R7: A winning class in bits 7 to 10 updates three registers. `dva` takes `vaddr`. `dstat` takes {`inst[31:26]`, `inst[25:21]`, `acc_flags`}, in bits 16:11, 10:6 and 5:0. `dva_form` takes data page-table base OR ((`vaddr` >> 13) << 3).
- R8: When `spec`, `req_pte` or `req_nofault` is set, the data capture registers keep their values, and entry still happens.
- R9: A winning class in bits 2 or 3 with `spec` clear updates two registers. `itag` takes `pc`. `iva_form` takes instruction page-table base OR ((`pc` >> 13) << 3). With `spec` set, both keep their values.
- R10: Each class has a 16-bit counter in `evt_cnt[16k+15:16k]`. It counts accepted entries of its class and saturates at 0xFFFF.
- R11: `arith_req` never redirects and never changes `new_pc`. It sets `unsup_err`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fault_req | input | 12 | Fault-class request bits |
| arith_req | input | 1 | Arithmetic trap request (unsupported) |
| spec | input | 1 | Request is speculative |
| req_pte | input | 1 | Request is a page-table-entry load |
| req_nofault | input | 1 | Request is a no-fault access |
| acc_flags | input | 6 | Access flags for the data status word |
| pc | input | 64 | Faulting PC |
| vaddr | input | 64 | Data virtual address |
| inst | input | 32 | Faulting instruction word |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 2 | Configuration register select |
| cfg_wdata | input | 64 | Configuration write data |
| redirect | output | 1 | Fetch redirect, high one cycle per entry |
| new_pc | output | 64 | Handler entry PC |
| next_pc | output | 64 | Entry PC plus 4 |
| exc_addr | output | 64 | Exception restart address |
| dva | output | 64 | Captured data fault address |
| dstat | output | 17 | Data fault status word |
| dva_form | output | 64 | Data formatted page-table address |
| itag | output | 64 | Captured instruction fault PC |
| iva_form | output | 64 | Instruction formatted page-table address |
| unsup_err | output | 1 | Sticky unsupported-trap flag |
| evt_cnt | output | 192 | Per-class entry counters, 16 bits each |

## Verification
The assertions assume the configuration port and the fault inputs are stable around each clock edge. They also assume `spec`, `req_pte` and `req_nofault` are meaningful only in a cycle that carries a request. The stimulus drives every input on the falling edge, and clears the qualifier bits together with the request. The bench sweeps every class alone, every pair of classes for priority, and every suppression qualifier. It also holds one class long enough to reach counter saturation.

// File: rtl/exc_entry.sv
module exc_entry #(
  parameter int XLEN = 64,
  parameter int PG_SHIFT = 13,
  parameter int CNT_W = 16,
  localparam int NCLS = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCLS-1:0]       fault_req,
  input  logic                  arith_req,
  input  logic                  spec,
  input  logic                  req_pte,
  input  logic                  req_nofault,
  input  logic [5:0]            acc_flags,
  input  logic [XLEN-1:0]       pc,
  input  logic [XLEN-1:0]       vaddr,
  input  logic [31:0]           inst,
  input  logic                  cfg_we,
  input  logic [1:0]            cfg_sel,
  input  logic [XLEN-1:0]       cfg_wdata,
  output logic                  redirect,
  output logic [XLEN-1:0]       new_pc,
  output logic [XLEN-1:0]       next_pc,
  output logic [XLEN-1:0]       exc_addr,
  output logic [XLEN-1:0]       dva,
  output logic [16:0]           dstat,
  output logic [XLEN-1:0]       dva_form,
  output logic [XLEN-1:0]       itag,
  output logic [XLEN-1:0]       iva_form,
  output logic                  unsup_err,
  output logic [NCLS*CNT_W-1:0] evt_cnt
);

  localparam int SEL_W = $clog2(NCLS);
  localparam int PAL_IDX = 6;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [XLEN-1:0] hbase, dptb, iptb;
  logic [CNT_W-1:0] cnt [NCLS];
  logic [SEL_W-1:0] sel;
  logic any_req;
  logic [XLEN-1:0] entry;
  logic is_data, is_instr, data_ok;

  function automatic logic [15:0] vec_of(input logic [SEL_W-1:0] k);
    case (k)
      4'd0:    vec_of = 16'h0001;
      4'd1:    vec_of = 16'h0401;
      4'd2:    vec_of = 16'h0181;
      4'd3:    vec_of = 16'h0081;
      4'd4:    vec_of = 16'h0481;
      4'd5:    vec_of = 16'h0581;
      4'd6:    vec_of = 16'h2001;
      4'd7:    vec_of = 16'h0201;
      4'd8:    vec_of = 16'h0281;
      4'd9:    vec_of = 16'h0381;
      4'd10:   vec_of = 16'h0301;
      default: vec_of = 16'h0101;
    endcase
  endfunction

  always_comb begin
    sel = '0;
    for (int i = NCLS - 1; i >= 0; i--)
      if (fault_req[i]) sel = SEL_W'(i);
  end

  assign any_req  = |fault_req;
  assign entry    = hbase + XLEN'(vec_of(sel));
  assign is_data  = (sel >= SEL_W'(7)) && (sel <= SEL_W'(10));
  assign is_instr = (sel == SEL_W'(2)) || (sel == SEL_W'(3));
  assign data_ok  = !spec && !req_pte && !req_nofault;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hbase     <= '0;
      dptb      <= '0;
      iptb      <= '0;
      redirect  <= 1'b0;
      new_pc    <= '0;
      next_pc   <= '0;
      exc_addr  <= '0;
      dva       <= '0;
      dstat     <= '0;
      dva_form  <= '0;
      itag      <= '0;
      iva_form  <= '0;
      unsup_err <= 1'b0;
    end else begin
      redirect <= any_req;
      if (arith_req) unsup_err <= 1'b1;
      if (cfg_we) begin
        case (cfg_sel)
          2'd0: hbase <= cfg_wdata;
          2'd1: dptb  <= cfg_wdata;
          2'd2: iptb  <= cfg_wdata;
          default: ;
        endcase
      end
      if (any_req) begin
        new_pc  <= entry;
        next_pc <= entry + XLEN'(4);
        if (sel == SEL_W'(PAL_IDX))
          exc_addr <= ((pc[1:0] == 2'b00) ? pc : exc_addr) + XLEN'(4);
        else
          exc_addr <= pc;
        if (is_data && data_ok) begin
          dva      <= vaddr;
          dstat    <= {inst[31:26], inst[25:21], acc_flags};
          dva_form <= dptb | ((vaddr >> PG_SHIFT) << 3);
        end
        if (is_instr && !spec) begin
          itag     <= pc;
          iva_form <= iptb | ((pc >> PG_SHIFT) << 3);
        end
      end
    end
  end

  for (genvar g = 0; g < NCLS; g++) begin : g_cnt
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt[g] <= '0;
      else if (any_req && sel == SEL_W'(g) && cnt[g] != CNT_MAX)
        cnt[g] <= cnt[g] + CNT_W'(1);
    end
    assign evt_cnt[g*CNT_W +: CNT_W] = cnt[g];

    assert_cnt_mono_R10: assert property (@(posedge clk) disable iff (!rst_n)
      cnt[g] >= $past(cnt[g]));
  end

  assert_next_pc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |-> next_pc == new_pc + XLEN'(4));

  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !any_req |=> !redirect);

  assert_unsup_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    unsup_err |=> unsup_err);

  assert_arith_no_pc_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (arith_req && !any_req) |=> $stable(new_pc));

  assert_data_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (spec || req_pte || req_nofault) |=> $stable(dva) && $stable(dstat));

  assert_instr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    spec |=> $stable(itag) && $stable(iva_form));

endmodule

// File: tb/sim_exc_entry.sv
module sim_exc_entry;
  logic clk = 0, rst_n = 0;
  logic [11:0] fault_req = '0;
  logic arith_req = 0, spec = 0, req_pte = 0, req_nofault = 0;
  logic [5:0] acc_flags = '0;
  logic [63:0] pc = '0, vaddr = '0, cfg_wdata = '0;
  logic [31:0] inst = '0;
  logic cfg_we = 0;
  logic [1:0] cfg_sel = '0;
  logic redirect, unsup_err;
  logic [63:0] new_pc, next_pc, exc_addr, dva, dva_form, itag, iva_form;
  logic [16:0] dstat;
  logic [191:0] evt_cnt;

  exc_entry u0 (.*);

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0, cycles = 0;
  logic [63:0] e_hb, e_dp, e_ip, e_exc, e_dva, e_dvf, e_itag, e_ivf;
  logic [16:0] e_dst;
  int e_cnt [12];

  function automatic logic [15:0] vec(input int k);
    case (k)
      0: vec = 16'h0001;  1: vec = 16'h0401;  2: vec = 16'h0181;
      3: vec = 16'h0081;  4: vec = 16'h0481;  5: vec = 16'h0581;
      6: vec = 16'h2001;  7: vec = 16'h0201;  8: vec = 16'h0281;
      9: vec = 16'h0381;  10: vec = 16'h0301; default: vec = 16'h0101;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cycles);
      summary();
    end
  end

  task automatic cfg(input logic [1:0] s, input logic [63:0] d);
    cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic fire(input logic [11:0] rq, input logic s, p, n,
                      input logic [63:0] ipc, iva, input logic [31:0] ins,
                      input logic [5:0] fl);
    int w = 0;
    for (int i = 11; i >= 0; i--) if (rq[i]) w = i;
    fault_req = rq; spec = s; req_pte = p; req_nofault = n;
    pc = ipc; vaddr = iva; inst = ins; acc_flags = fl;
    if (w == 6) e_exc = ((ipc[1:0] == 2'b00) ? ipc : e_exc) + 64'd4;
    else e_exc = ipc;
    if (w >= 7 && w <= 10 && !s && !p && !n) begin
      e_dva = iva; e_dst = {ins[31:26], ins[25:21], fl};
      e_dvf = e_dp | ((iva >> 13) << 3);
    end
    if ((w == 2 || w == 3) && !s) begin
      e_itag = ipc; e_ivf = e_ip | ((ipc >> 13) << 3);
    end
    if (e_cnt[w] < 65535) e_cnt[w]++;
    @(negedge clk);
    fault_req = '0; spec = 0; req_pte = 0; req_nofault = 0;
    chk($sformatf("R2 redirect cls%0d", w), 64'(redirect), 64'd1);
    chk($sformatf("R3 R4 new_pc cls%0d", w), new_pc, e_hb + 64'(vec(w)));
    chk($sformatf("R2 next_pc cls%0d", w), next_pc, e_hb + 64'(vec(w)) + 64'd4);
    chk($sformatf("R5 R6 exc_addr cls%0d", w), exc_addr, e_exc);
    chk($sformatf("R7 R8 dva cls%0d", w), dva, e_dva);
    chk($sformatf("R7 R8 dstat cls%0d", w), 64'(dstat), 64'(e_dst));
    chk($sformatf("R7 R8 dva_form cls%0d", w), dva_form, e_dvf);
    chk($sformatf("R9 itag cls%0d", w), itag, e_itag);
    chk($sformatf("R9 iva_form cls%0d", w), iva_form, e_ivf);
    chk($sformatf("R10 cnt cls%0d", w), 64'(evt_cnt[w*16 +: 16]), 64'(e_cnt[w]));
    @(negedge clk);
    chk("R2 redirect drops", 64'(redirect), 64'd0);
  endtask

  initial begin
    e_hb = 0; e_dp = 0; e_ip = 0; e_exc = 0; e_dva = 0; e_dvf = 0;
    e_itag = 0; e_ivf = 0; e_dst = 0;
    for (int i = 0; i < 12; i++) e_cnt[i] = 0;
    repeat (3) @(negedge clk);
    chk("R1 redirect", 64'(redirect), 0);
    chk("R1 new_pc", new_pc, 0);
    chk("R1 exc_addr", exc_addr, 0);
    chk("R1 counters", 64'(|evt_cnt), 0);
    chk("R1 unsup", 64'(unsup_err), 0);
    rst_n = 1;
    @(negedge clk);
    e_hb = 64'hFFFF_0000_0001_0000; cfg(2'd0, e_hb);
    e_dp = 64'h0000_0002_0000_0005; cfg(2'd1, e_dp);
    e_ip = 64'h0000_0003_0000_0006; cfg(2'd2, e_ip);

    for (int k = 0; k < 12; k++)
      fire(12'(1 << k), 0, 0, 0, 64'h0000_0001_2345_6780 + 64'(k * 64'h2040),
           64'h0000_00AB_CDEF_0000 + 64'(k * 64'h12345), 32'hA5C3_0000 + 32'(k * 32'h0421_0000),
           6'(k * 5 + 3));

    fire(12'h040, 0, 0, 0, 64'h0000_0000_0000_1002, 64'h0, 32'h0, 6'h0);
    fire(12'h040, 0, 0, 0, 64'h0000_0000_0000_2001, 64'h0, 32'h0, 6'h0);
    fire(12'h040, 0, 0, 0, 64'h0000_0000_0000_3000, 64'h0, 32'h0, 6'h0);

    fire(12'h080, 1, 0, 0, 64'h100, 64'h7777_0000, 32'hFFFF_FFFF, 6'h3F);
    fire(12'h100, 0, 1, 0, 64'h104, 64'h8888_0000, 32'hFFFF_FFFF, 6'h3F);
    fire(12'h200, 0, 0, 1, 64'h108, 64'h9999_0000, 32'hFFFF_FFFF, 6'h3F);
    fire(12'h400, 0, 0, 0, 64'h10C, 64'hAAAA_E000, 32'h0FC0_0000, 6'h15);
    fire(12'h004, 1, 0, 0, 64'h5555_0000, 64'h0, 32'h0, 6'h0);
    fire(12'h008, 0, 1, 1, 64'h6666_2000, 64'h0, 32'h0, 6'h0);

    for (int i = 0; i < 12; i++)
      for (int j = i + 1; j < 12; j++)
        fire(12'((1 << i) | (1 << j)), 0, 0, 0, 64'h4000 + 64'(i * 256 + j * 4),
             64'h0002_0000 + 64'(j * 64'h2000), 32'(i * 32'h0100_0000 + j), 6'(i + j));

    arith_req = 1;
    @(negedge clk);
    arith_req = 0;
    chk("R11 arith no redirect", 64'(redirect), 0);
    chk("R11 arith new_pc kept", new_pc, e_hb + 64'(vec(10)));
    chk("R11 unsup set", 64'(unsup_err), 1);
    repeat (4) @(negedge clk);
    chk("R11 unsup sticky", 64'(unsup_err), 1);

    fault_req = 12'h800; pc = 64'h9000;
    for (int n = 0; n < 65600; n++) begin
      if (e_cnt[11] < 65535) e_cnt[11]++;
      @(negedge clk);
    end
    fault_req = '0;
    chk("R10 saturate", 64'(evt_cnt[11*16 +: 16]), 64'(e_cnt[11]));
    chk("R10 saturate value", 64'(evt_cnt[11*16 +: 16]), 64'hFFFF);
    chk("R5 exc_addr held class", exc_addr, 64'h9000);
    fire(12'h800, 0, 0, 0, 64'h9004, 64'h0, 32'h0, 6'h0);
    chk("R10 other counter", 64'(evt_cnt[0 +: 16]), 64'(e_cnt[0]));

    rst_n = 0;
    @(negedge clk);
    chk("R1 unsup cleared", 64'(unsup_err), 0);
    chk("R1 counters cleared", 64'(|evt_cnt), 0);
    summary();
  end
endmodule